// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block steers the hazard handling of an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback) whose instruction fetch and data accesses share a single one-request-per-cycle memory. Each cycle it looks at the register specifiers and flags of the instructions in decode, execute and memory, and at the taken-branch outcome from execute. From these it drives the datapath's hazard controls: PC hold, decode-register hold, bubble and flush controls, the branch redirect, and the bypass selects for both ALU operands.

It handles three kinds of hazard. When the memory stage holds a load or store, fetch cannot use the port and is delayed by one bubble. An operand is bypassed from the EX/MEM or MEM/WB register when it was produced by an instruction just ahead. A load whose result is read by the very next instruction costs exactly one interlock cycle. Branches are predicted not taken. When a branch is resolved taken in execute, the two younger instructions are cleared and fetch is redirected to the target.

The stall controls and the flush controls are combinational in the current cycle's stage contents. The bypass selects are computed while the consumer is in decode and registered, so they are valid for that instruction once it sits in execute. The register file is taken to be write-before-read, so no bypass from the writeback stage itself is needed.

Top module: `hzd_ctrl`

## Requirements
- R1: After synchronous active-high reset, both bypass selects read 0 (register file) until an instruction in decode has been evaluated.
- R2: When `mem_req` is 1 and there is no taken branch and no load-use interlock, `pc_hold` and `fetch_bubble` are 1, while `ifid_hold` and `idex_bubble` are 0.
- R3: A source marked used, nonzero, equal to `ex_rd` with `ex_wen`=1 and `ex_load`=0 gives a select of 1 (EX/MEM) in the following cycle.
- R4: A source marked used, nonzero, equal to `mem_rd` with `mem_wen`=1 and not matching execute gives a select of 2 (MEM/WB) in the following cycle. Select 0 means register file, and the value 3 never appears.
- R5: When a source matches both `ex_rd` and `mem_rd` with both write enables set, the EX/MEM select (1) is chosen.
- R6: Register 0 is never bypassed (its select is 0 in the following cycle) and never causes an interlock.
- R7: When `ex_load`=1, `ex_wen`=1, and a used nonzero decode source equals `ex_rd`, and there is no taken branch: `pc_hold`, `ifid_hold` and `idex_bubble` are 1 and `fetch_bubble` is 0. Both selects are 0 in the following cycle.
- R8: A load-use costs one cycle only. Once the load has moved to memory, the waiting consumer is not stalled again and receives select 2 one cycle later.
- R9: When `ex_taken` is 1, `ifid_flush`, `idex_flush` and `pc_redirect` are 1. At the same time `pc_hold`, `ifid_hold`, `idex_bubble` and `fetch_bubble` are 0, even if a port conflict or load-use is present. Both selects are 0 in the following cycle.
- R10: A source whose use flag is 0 causes neither a bypass nor an interlock.
- R11: When `ex_taken` is 0, `ifid_flush`, `idex_flush` and `pc_redirect` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_AW | Decode-stage first source register |
| id_rs2 | input | REG_AW | Decode-stage second source register |
| id_use1 | input | 1 | Decode instruction reads its first source |
| id_use2 | input | 1 | Decode instruction reads its second source |
| ex_rd | input | REG_AW | Execute-stage destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_taken | input | 1 | Branch in execute resolved taken |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_req | input | 1 | Memory-stage instruction uses the memory port |
| fwd_a | output | 2 | Bypass select for ALU operand A (0 file, 1 EX/MEM, 2 MEM/WB) |
| fwd_b | output | 2 | Bypass select for ALU operand B (same encoding) |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| fetch_bubble | output | 1 | Load an empty slot into fetch/decode (port conflict) |
| idex_bubble | output | 1 | Load an empty slot into decode/execute (interlock) |
| ifid_flush | output | 1 | Clear the fetch/decode register (wrong path) |
| idex_flush | output | 1 | Clear the decode/execute register (wrong path) |
| pc_redirect | output | 1 | Load the PC with the branch target |

## Verification
The bench goes after the cycles where hazards overlap. One case is a taken branch that arrives together with a load-use and a port conflict; a controller that let a stall win there would hold the PC and lose the redirect. Another is a producer in both execute and memory with the same destination; reversed priority would feed the older, stale value. Register 0 and unused sources are also targeted, because a careless match would stall or bypass on them. The follow-up cycle after a load-use is checked so that a second stall, or a missing MEM/WB select, shows up as a wrong `pc_hold` or operand select.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EXM = 2'd1,
    FWD_MWB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hzd_match.sv
// Compares one decode source against the producers in execute and memory.
module hzd_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              src_use,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  output logic              hit_ex,
  output logic              hit_mem
);
  logic live;
  assign live    = src_use && (src != '0);
  assign hit_ex  = live && ex_wen  && (src == ex_rd);
  assign hit_mem = live && mem_wen && (src == mem_rd);
endmodule

// File: rtl/hzd_interlock.sv
// Stall and flush decisions, kept apart from the bypass selection.
module hzd_interlock #(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] hit_ex,
  input  logic            ex_load,
  input  logic            ex_taken,
  input  logic            mem_req,
  output logic            load_use,
  output logic            pc_hold,
  output logic            ifid_hold,
  output logic            fetch_bubble,
  output logic            idex_bubble,
  output logic            ifid_flush,
  output logic            idex_flush,
  output logic            pc_redirect
);
  logic stall_lu;

  assign load_use = ex_load && (|hit_ex);
  assign stall_lu = load_use && !ex_taken;

  always_comb begin
    pc_redirect  = ex_taken;
    ifid_flush   = ex_taken;
    idex_flush   = ex_taken;
    ifid_hold    = stall_lu;
    idex_bubble  = stall_lu;
    pc_hold      = !ex_taken && (load_use || mem_req);
    fetch_bubble = !ex_taken && !load_use && mem_req;
  end
endmodule

// File: rtl/hzd_fwd_reg.sv
// Bypass select chosen in decode, registered for use in execute.
module hzd_fwd_reg
  import hzd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     kill,
  input  logic     hit_ex,
  input  logic     hit_mem,
  output fwd_sel_e sel
);
  always_ff @(posedge clk) begin
    if (rst || kill)   sel <= FWD_RF;
    else if (hit_ex)   sel <= FWD_EXM;
    else if (hit_mem)  sel <= FWD_MWB;
    else               sel <= FWD_RF;
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use1,
  input  logic              id_use2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic              ex_taken,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_req,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              fetch_bubble,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic              idex_flush,
  output logic              pc_redirect
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] src;
  logic [NSRC-1:0]             src_use;
  logic [NSRC-1:0]             hit_ex;
  logic [NSRC-1:0]             hit_mem;
  fwd_sel_e                    sel [NSRC];
  logic                        load_use;
  logic                        kill;

  assign src[0]     = id_rs1;
  assign src[1]     = id_rs2;
  assign src_use[0] = id_use1;
  assign src_use[1] = id_use2;

  // A slot that enters execute as a bubble or as flushed carries no bypass.
  assign kill = load_use || ex_taken;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hzd_match #(.REG_AW(REG_AW)) u_match (
      .src     (src[i]),
      .src_use (src_use[i]),
      .ex_rd   (ex_rd),
      .ex_wen  (ex_wen),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .hit_ex  (hit_ex[i]),
      .hit_mem (hit_mem[i])
    );

    hzd_fwd_reg u_sel (
      .clk     (clk),
      .rst     (rst),
      .kill    (kill),
      .hit_ex  (hit_ex[i]),
      .hit_mem (hit_mem[i]),
      .sel     (sel[i])
    );
  end

  hzd_interlock #(.NSRC(NSRC)) u_lock (
    .hit_ex       (hit_ex),
    .ex_load      (ex_load),
    .ex_taken     (ex_taken),
    .mem_req      (mem_req),
    .load_use     (load_use),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .fetch_bubble (fetch_bubble),
    .idex_bubble  (idex_bubble),
    .ifid_flush   (ifid_flush),
    .idex_flush   (idex_flush),
    .pc_redirect  (pc_redirect)
  );

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              ex_taken,
  input logic              mem_req,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              fetch_bubble,
  input logic              idex_bubble,
  input logic              ifid_flush,
  input logic              idex_flush,
  input logic              pc_redirect
);
  assert_port_stall_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && !ex_taken |-> pc_hold);

  assert_sel_legal_R4: assert property (@(posedge clk) disable iff (rst)
    fwd_a != 2'd3 && fwd_b != 2'd3);

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
    id_rs1 == '0 |=> fwd_a == 2'd0);

  assert_zero_reg_b_R6: assert property (@(posedge clk) disable iff (rst)
    id_rs2 == '0 |=> fwd_b == 2'd0);

  assert_interlock_set_R7: assert property (@(posedge clk) disable iff (rst)
    ifid_hold |-> pc_hold && idex_bubble && !fetch_bubble);

  assert_bubble_nosel_R7: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |=> fwd_a == 2'd0 && fwd_b == 2'd0);

  assert_flush_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ex_taken |-> ifid_flush && idex_flush && pc_redirect && !pc_hold
                 && !ifid_hold && !idex_bubble && !fetch_bubble);

  assert_flush_nosel_R9: assert property (@(posedge clk) disable iff (rst)
    ex_taken |=> fwd_a == 2'd0 && fwd_b == 2'd0);

  assert_no_redirect_R11: assert property (@(posedge clk) disable iff (rst)
    !ex_taken |-> !pc_redirect && !ifid_flush && !idex_flush);
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/hzd_ctrl_bench.sv
`timescale 1ns/1ps
module hzd_ctrl_bench;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic          id_use1 = 0, id_use2 = 0, ex_wen = 0, ex_load = 0;
  logic          ex_taken = 0, mem_wen = 0, mem_req = 0;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_hold, ifid_hold, fetch_bubble, idex_bubble;
  logic          ifid_flush, idex_flush, pc_redirect;

  int n_chk = 0;
  int n_bad = 0;
  int exp_a = 0;
  int exp_b = 0;

  always #2.5 clk = ~clk;

  hzd_ctrl #(.REG_AW(AW)) u_hzd_ctrl (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit hx(input logic [AW-1:0] rs, input logic u);
    return u && rs != 0 && ex_wen && rs == ex_rd;
  endfunction

  function automatic bit hm(input logic [AW-1:0] rs, input logic u);
    return u && rs != 0 && mem_wen && rs == mem_rd;
  endfunction

  function automatic int nsel(input logic [AW-1:0] rs, input logic u, input bit killed);
    if (killed) return 0;
    if (hx(rs, u)) return 1;
    if (hm(rs, u)) return 2;
    return 0;
  endfunction

  function automatic string pick(input string t, input string d);
    return (t == "") ? d : t;
  endfunction

  // Inputs are set at a falling edge; outputs are checked 1 ns later.
  task automatic step(input string tag);
    bit lu, tk;
    #1;
    tk = ex_taken;
    lu = ex_load && (hx(id_rs1, id_use1) || hx(id_rs2, id_use2));
    check(pick(tag, "R5"), "fwd_a", fwd_a, exp_a);
    check(pick(tag, "R5"), "fwd_b", fwd_b, exp_b);
    check(pick(tag, "R2"), "pc_hold", pc_hold, int'(!tk && (lu || mem_req)));
    check(pick(tag, "R2"), "fetch_bubble", fetch_bubble, int'(!tk && !lu && mem_req));
    check(pick(tag, "R7"), "ifid_hold", ifid_hold, int'(!tk && lu));
    check(pick(tag, "R7"), "idex_bubble", idex_bubble, int'(!tk && lu));
    check(pick(tag, "R9"), "ifid_flush", ifid_flush, int'(tk));
    check(pick(tag, "R9"), "idex_flush", idex_flush, int'(tk));
    check(pick(tag, "R11"), "pc_redirect", pc_redirect, int'(tk));
    exp_a = nsel(id_rs1, id_use1, lu || tk);
    exp_b = nsel(id_rs2, id_use2, lu || tk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    id_rs1 = 0; id_rs2 = 0; id_use1 = 0; id_use2 = 0;
    ex_rd = 0; ex_wen = 0; ex_load = 0; ex_taken = 0;
    mem_rd = 0; mem_wen = 0; mem_req = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    exp_a = 0; exp_b = 0;
    clear_in();
    step("R1");                                   // reset state

    // R3 back-to-back RAW from execute
    ex_rd = 5; ex_wen = 1; id_rs1 = 5; id_use1 = 1;
    step("R3");
    clear_in(); step("R3");                        // fwd_a must be 1 here

    // R4 producer one further ahead
    mem_rd = 6; mem_wen = 1; id_rs2 = 6; id_use2 = 1;
    step("R4");
    clear_in(); step("R4");                        // fwd_b must be 2

    // R5 both stages produce the same register
    ex_rd = 7; ex_wen = 1; mem_rd = 7; mem_wen = 1; id_rs1 = 7; id_use1 = 1;
    id_rs2 = 7; id_use2 = 1;
    step("R5");
    clear_in(); step("R5");                        // both selects 1

    // R6 register 0 load producer
    ex_rd = 0; ex_wen = 1; ex_load = 1; mem_rd = 0; mem_wen = 1;
    id_rs1 = 0; id_use1 = 1; id_rs2 = 0; id_use2 = 1;
    step("R6");
    clear_in(); step("R6");

    // R10 unused source matching a load
    ex_rd = 9; ex_wen = 1; ex_load = 1; id_rs1 = 9; id_use1 = 0;
    mem_rd = 9; mem_wen = 1; id_rs2 = 9; id_use2 = 0;
    step("R10");
    clear_in(); step("R10");

    // R7 / R8 load-use, then one stall only
    ex_rd = 3; ex_wen = 1; ex_load = 1; id_rs2 = 3; id_use2 = 1;
    step("R7");
    clear_in(); id_rs2 = 3; id_use2 = 1;
    mem_rd = 3; mem_wen = 1; mem_req = 1;           // load now in memory, bubble in execute
    step("R8");
    clear_in(); step("R8");                         // fwd_b must be 2

    // R2 fetch conflict with a store in memory
    mem_req = 1; id_rs1 = 4; id_use1 = 1;
    step("R2");
    clear_in();

    // R9 taken branch together with load-use and port conflict
    ex_taken = 1; ex_rd = 2; ex_wen = 1; ex_load = 1; id_rs1 = 2; id_use1 = 1;
    mem_req = 1; mem_rd = 2; mem_wen = 1;
    step("R9");
    clear_in(); step("R9");                         // selects cleared

    // R11 quiet cycle
    step("R11");

    // Constrained random mix over a small register set to provoke hits
    for (int i = 0; i < 600; i++) begin
      id_rs1  = AW'($urandom % 4);
      id_rs2  = AW'($urandom % 4);
      id_use1 = 1'($urandom % 4 != 0);
      id_use2 = 1'($urandom % 2);
      ex_rd   = AW'($urandom % 4);
      ex_wen  = 1'($urandom % 3 != 0);
      ex_load = ex_wen && ($urandom % 3 == 0);
      ex_taken = 1'($urandom % 8 == 0);
      mem_rd  = AW'($urandom % 4);
      mem_wen = 1'($urandom % 2);
      mem_req = 1'($urandom % 3 == 0);
      step("");
    end

    clear_in(); step("");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule